// File: doc/BRIEF.md
# Decapsulation Key Stream Parser

This block takes a decapsulation key delivered as a byte stream and sorts it into storage. Each cycle it may receive one byte, a 12-bit byte address and a write-enable. The address is decoded against region limits that depend on the security level K (2, 3 or 4). The key spans 768·K + 96 bytes, which is 1632, 2400 or 3168 bytes. The address decides where each byte goes:

- the inner secret-key byte memory;
- the encapsulation-key byte memory;
- a 256-bit public-key hash register;
- a 256-bit implicit-rejection seed register.

Downstream logic, or a test harness, reads either byte memory back through a registered debug port. The two wide registers are visible as plain outputs. The block does not interpret the stored contents: it only places them.

Top module: `dk_stream_parser`

## Requirements
- R1: When K is valid, a write with address below 384·K stores the byte in the secret-key memory at that same address. It reads back with `rd_sel_i` = 1.
- R2: When K is valid, a write with address from 384·K up to 768·K + 31 stores the byte in the encapsulation-key memory at local address (address − 384·K). It reads back with `rd_sel_i` = 0.
- R3: A write to address 768·K + 32 + j (j = 0..31) places the byte in `pk_hash_o` bits 8j+7 down to 8j. The other 31 bytes of that register keep their values.
- R4: A write to address 768·K + 64 + j (j = 0..31) places the byte in `rej_seed_o` bits 8j+7 down to 8j. The other 31 bytes of that register keep their values.
- R5: A synchronous active-high reset clears `pk_hash_o` and `rej_seed_o` to zero.
- R6: A write with address at or above 768·K + 96 changes no memory and no register.
- R7: While `wr_en_i` is low, nothing is written, whatever the address and data.
- R8: Region limits follow the current `key_k_i` value. For example, address 768 is secret-key address 768 when K = 3, and encapsulation-key local address 0 when K = 2.
- R9: A debug read presents the byte on `rd_byte_o` one clock edge after the select and address are applied. Until that edge the previous read result stays on the output.
- R10: When `key_k_i` is not 2, 3 or 4, every write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_k_i | input | 3 | Security level K (2, 3 or 4 are valid) |
| wr_en_i | input | 1 | Byte write strobe |
| wr_addr_i | input | 12 | Byte address within the key |
| wr_byte_i | input | 8 | Byte value |
| rd_sel_i | input | 1 | Debug read select: 0 encapsulation key, 1 secret key |
| rd_addr_i | input | 11 | Debug read local address |
| rd_byte_o | output | 8 | Debug read data, one cycle after the request |
| pk_hash_o | output | 256 | Public-key hash register |
| rej_seed_o | output | 256 | Implicit-rejection seed register |

## Verification
A byte written in cycle N, whether to memory or to a wide register, is committed at the clock edge that ends cycle N. The wide registers therefore show the new value from that edge onward. A memory byte needs one more edge to reach `rd_byte_o` through the registered read.

The bench drives every input on the falling edge and samples on the next falling edge. This puts exactly one rising edge between a read request and its check. It also samples the output just after changing the request, before any edge, to confirm that the previous result is still held.

The checker follows the same timing. It registers the lane and data of each hash or seed write and compares them against the register one edge later. For writes that must have no effect, it expects both wide registers to be stable at the following edge.

// File: rtl/dkp_pkg.sv
package dkp_pkg;

    localparam int ADDR_W     = 12;
    localparam int BYTE_W     = 8;
    localparam int K_MAX      = 4;
    localparam int POLY_BYTES = 384;
    localparam int WIDE_BYTES = 32;
    localparam int WIDE_W     = WIDE_BYTES * BYTE_W;
    localparam int LANE_W     = $clog2(WIDE_BYTES);
    localparam int SK_DEPTH   = POLY_BYTES * K_MAX;
    localparam int EK_DEPTH   = POLY_BYTES * K_MAX + WIDE_BYTES;
    localparam int MEM_AW     = $clog2(EK_DEPTH);

    typedef enum logic [2:0] {
        DST_NONE = 3'd0,
        DST_SK   = 3'd1,
        DST_EK   = 3'd2,
        DST_HASH = 3'd3,
        DST_SEED = 3'd4
    } dst_e;

    typedef struct packed {
        dst_e              dst;
        logic [MEM_AW-1:0] mem_off;
        logic [LANE_W-1:0] lane;
    } route_t;

    function automatic logic k_supported(input logic [2:0] k);
        return (k == 3'd2) || (k == 3'd3) || (k == 3'd4);
    endfunction

    function automatic logic [ADDR_W-1:0] widen_k(input logic [2:0] k);
        return {{(ADDR_W-3){1'b0}}, k};
    endfunction

    // first address past the inner secret key
    function automatic logic [ADDR_W-1:0] sk_limit(input logic [2:0] k);
        return widen_k(k) * ADDR_W'(POLY_BYTES);
    endfunction

    // first address past the encapsulation key
    function automatic logic [ADDR_W-1:0] ek_limit(input logic [2:0] k);
        return widen_k(k) * ADDR_W'(2 * POLY_BYTES) + ADDR_W'(WIDE_BYTES);
    endfunction

endpackage

// File: rtl/dkp_route_decode.sv
module dkp_route_decode
    import dkp_pkg::*;
(
    input  logic [2:0]        key_k,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output route_t            route
);

    logic [ADDR_W-1:0] sk_end;
    logic [ADDR_W-1:0] ek_end;
    logic [ADDR_W-1:0] hash_end;
    logic [ADDR_W-1:0] seed_end;

    assign sk_end   = sk_limit(key_k);
    assign ek_end   = ek_limit(key_k);
    assign hash_end = ek_end + ADDR_W'(WIDE_BYTES);
    assign seed_end = hash_end + ADDR_W'(WIDE_BYTES);

    always_comb begin
        route = '{dst: DST_NONE, mem_off: '0, lane: '0};
        if (wr_en && k_supported(key_k)) begin
            if (addr < sk_end) begin
                route.dst     = DST_SK;
                route.mem_off = MEM_AW'(addr);
            end else if (addr < ek_end) begin
                route.dst     = DST_EK;
                route.mem_off = MEM_AW'(addr - sk_end);
            end else if (addr < hash_end) begin
                route.dst  = DST_HASH;
                route.lane = LANE_W'(addr - ek_end);
            end else if (addr < seed_end) begin
                route.dst  = DST_SEED;
                route.lane = LANE_W'(addr - hash_end);
            end
        end
    end

endmodule

// File: rtl/dkp_byte_ram.sv
module dkp_byte_ram #(
    parameter int DEPTH  = 1568,
    parameter int AW     = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (int'(waddr) < DEPTH)) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (int'(raddr) < DEPTH) begin
            rdata <= mem[raddr];
        end else begin
            rdata <= '0;
        end
    end

endmodule

// File: rtl/dkp_lane_reg.sv
module dkp_lane_reg #(
    parameter int NBYTES = 32,
    parameter int BW     = 8,
    localparam int LW    = $clog2(NBYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [LW-1:0]    lane,
    input  logic [BW-1:0]    data,
    output logic [NBYTES*BW-1:0] q
);

    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                q[b*BW +: BW] <= '0;
            end else if (we && (lane == LW'(b))) begin
                q[b*BW +: BW] <= data;
            end
        end
    end

endmodule

// File: rtl/dk_stream_parser.sv
module dk_stream_parser
    import dkp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        key_k_i,
    input  logic              wr_en_i,
    input  logic [11:0]       wr_addr_i,
    input  logic [7:0]        wr_byte_i,
    input  logic              rd_sel_i,
    input  logic [10:0]       rd_addr_i,
    output logic [7:0]        rd_byte_o,
    output logic [255:0]      pk_hash_o,
    output logic [255:0]      rej_seed_o
);

    route_t            route;
    logic [BYTE_W-1:0] sk_q;
    logic [BYTE_W-1:0] ek_q;
    logic              sel_q;

    dkp_route_decode u_decode (
        .key_k (key_k_i),
        .wr_en (wr_en_i),
        .addr  (wr_addr_i),
        .route (route)
    );

    dkp_byte_ram #(.DEPTH(SK_DEPTH), .AW(MEM_AW), .DATA_W(BYTE_W)) u_sk_ram (
        .clk   (clk),
        .rst   (rst),
        .we    (route.dst == DST_SK),
        .waddr (route.mem_off),
        .wdata (wr_byte_i),
        .raddr (rd_addr_i),
        .rdata (sk_q)
    );

    dkp_byte_ram #(.DEPTH(EK_DEPTH), .AW(MEM_AW), .DATA_W(BYTE_W)) u_ek_ram (
        .clk   (clk),
        .rst   (rst),
        .we    (route.dst == DST_EK),
        .waddr (route.mem_off),
        .wdata (wr_byte_i),
        .raddr (rd_addr_i),
        .rdata (ek_q)
    );

    dkp_lane_reg #(.NBYTES(WIDE_BYTES), .BW(BYTE_W)) u_hash_reg (
        .clk  (clk),
        .rst  (rst),
        .we   (route.dst == DST_HASH),
        .lane (route.lane),
        .data (wr_byte_i),
        .q    (pk_hash_o)
    );

    dkp_lane_reg #(.NBYTES(WIDE_BYTES), .BW(BYTE_W)) u_seed_reg (
        .clk  (clk),
        .rst  (rst),
        .we   (route.dst == DST_SEED),
        .lane (route.lane),
        .data (wr_byte_i),
        .q    (rej_seed_o)
    );

    // select travels with the registered memory read
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= 1'b0;
        end else begin
            sel_q <= rd_sel_i;
        end
    end

    assign rd_byte_o = sel_q ? sk_q : ek_q;

endmodule

// File: rtl/dkp_parser_chk.sv
module dkp_parser_chk (
    input logic         clk,
    input logic         rst,
    input logic [2:0]   key_k_i,
    input logic         wr_en_i,
    input logic [11:0]  wr_addr_i,
    input logic [7:0]   wr_byte_i,
    input logic [255:0] pk_hash_o,
    input logic [255:0] rej_seed_o
);

    logic [11:0] k12;
    logic [11:0] hash_lo;
    logic [11:0] seed_lo;
    logic [11:0] key_len;
    logic        k_good;
    logic        hit_hash;
    logic        hit_seed;
    logic        hit_q_h;
    logic        hit_q_s;
    logic [4:0]  lane_q;
    logic [7:0]  byte_q;

    assign k12      = {9'd0, key_k_i};
    assign hash_lo  = (k12 << 9) + (k12 << 8) + 12'd32;
    assign seed_lo  = hash_lo + 12'd32;
    assign key_len  = seed_lo + 12'd32;
    assign k_good   = (key_k_i >= 3'd2) && (key_k_i <= 3'd4);
    assign hit_hash = wr_en_i && k_good && (wr_addr_i >= hash_lo) && (wr_addr_i < seed_lo);
    assign hit_seed = wr_en_i && k_good && (wr_addr_i >= seed_lo) && (wr_addr_i < key_len);

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q_h <= 1'b0;
            hit_q_s <= 1'b0;
            lane_q  <= '0;
            byte_q  <= '0;
        end else begin
            hit_q_h <= hit_hash;
            hit_q_s <= hit_seed;
            lane_q  <= hit_hash ? 5'(wr_addr_i - hash_lo) : 5'(wr_addr_i - seed_lo);
            byte_q  <= wr_byte_i;
        end
    end

    // R3
    hash_lane_chk: assert property (@(posedge clk) disable iff (rst)
        hit_q_h |-> (pk_hash_o[{lane_q, 3'b000} +: 8] == byte_q));

    // R4
    seed_lane_chk: assert property (@(posedge clk) disable iff (rst)
        hit_q_s |-> (rej_seed_o[{lane_q, 3'b000} +: 8] == byte_q));

    // R5
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> ((pk_hash_o == '0) && (rej_seed_o == '0)));

    // R6
    past_end_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && k_good && (wr_addr_i >= key_len)) |=>
        ($stable(pk_hash_o) && $stable(rej_seed_o)));

    // R7
    idle_we_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en_i |=> ($stable(pk_hash_o) && $stable(rej_seed_o)));

    // R10
    bad_k_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && !k_good) |=> ($stable(pk_hash_o) && $stable(rej_seed_o)));

endmodule

bind dk_stream_parser dkp_parser_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .key_k_i    (key_k_i),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_byte_i  (wr_byte_i),
    .pk_hash_o  (pk_hash_o),
    .rej_seed_o (rej_seed_o)
);

// File: tb/dk_stream_parser_bench.sv
`timescale 1ns/1ps
module dk_stream_parser_bench;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [2:0]   key_k_i = 3'd2;
    logic         wr_en_i = 1'b0;
    logic [11:0]  wr_addr_i = '0;
    logic [7:0]   wr_byte_i = '0;
    logic         rd_sel_i = 1'b0;
    logic [10:0]  rd_addr_i = '0;
    logic [7:0]   rd_byte_o;
    logic [255:0] pk_hash_o;
    logic [255:0] rej_seed_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [255:0] exp_hash;
    logic [255:0] exp_seed;

    dk_stream_parser u_dk_stream_parser (
        .clk        (clk),
        .rst        (rst),
        .key_k_i    (key_k_i),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_byte_i  (wr_byte_i),
        .rd_sel_i   (rd_sel_i),
        .rd_addr_i  (rd_addr_i),
        .rd_byte_o  (rd_byte_o),
        .pk_hash_o  (pk_hash_o),
        .rej_seed_o (rej_seed_o)
    );

    always #5 clk = ~clk;

    function automatic logic [7:0] pat(input int addr, input int salt);
        return 8'(addr * 13 + (addr >> 5) + salt);
    endfunction

    task automatic check(input string req, input logic [255:0] got,
                         input logic [255:0] exp, input string what);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic put(input int addr, input logic [7:0] b, input logic en);
        @(negedge clk);
        wr_en_i   = en;
        wr_addr_i = 12'(addr);
        wr_byte_i = b;
        @(negedge clk);
        wr_en_i   = 1'b0;
    endtask

    task automatic rd(input logic sel, input int addr, output logic [7:0] val);
        @(negedge clk);
        rd_sel_i  = sel;
        rd_addr_i = 11'(addr);
        @(negedge clk);
        val = rd_byte_o;
    endtask

    task automatic t_reset;
        check("R5", pk_hash_o, '0, "hash after reset");
        check("R5", rej_seed_o, '0, "seed after reset");
    endtask

    task automatic t_full_load(input int k, input int salt);
        int bad_sk = 0;
        int bad_ek = 0;
        int first_sk = -1;
        int first_ek = -1;
        logic [7:0] v;
        key_k_i = 3'(k);
        @(negedge clk);
        for (int a = 0; a < 768 * k + 96; a++) begin
            wr_en_i   = 1'b1;
            wr_addr_i = 12'(a);
            wr_byte_i = pat(a, salt);
            @(negedge clk);
        end
        wr_en_i = 1'b0;
        for (int j = 0; j < 32; j++) begin
            exp_hash[8*j +: 8] = pat(768 * k + 32 + j, salt);
            exp_seed[8*j +: 8] = pat(768 * k + 64 + j, salt);
        end
        check("R3", pk_hash_o, exp_hash, $sformatf("hash lanes K=%0d", k));
        check("R4", rej_seed_o, exp_seed, $sformatf("seed lanes K=%0d", k));
        for (int a = 0; a < 384 * k; a++) begin
            rd(1'b1, a, v);
            if (v !== pat(a, salt)) begin
                bad_sk++;
                if (first_sk < 0) first_sk = a;
            end
        end
        check("R1", 256'(bad_sk), 256'(0), $sformatf("secret mismatches K=%0d first %0d", k, first_sk));
        for (int a = 0; a < 384 * k + 32; a++) begin
            rd(1'b0, a, v);
            if (v !== pat(384 * k + a, salt)) begin
                bad_ek++;
                if (first_ek < 0) first_ek = a;
            end
        end
        check("R2", 256'(bad_ek), 256'(0), $sformatf("encap mismatches K=%0d first %0d", k, first_ek));
    endtask

    task automatic t_single_lane;
        // K=3: hash base 2336, lane 9; seed base 2368, lane 31
        key_k_i = 3'd3;
        put(2336 + 9, 8'h5A, 1'b1);
        exp_hash[8*9 +: 8] = 8'h5A;
        check("R3", pk_hash_o, exp_hash, "single hash lane 9");
        put(2368 + 31, 8'hC3, 1'b1);
        exp_seed[8*31 +: 8] = 8'hC3;
        check("R4", rej_seed_o, exp_seed, "single seed lane 31");
    endtask

    task automatic t_past_end;
        logic [7:0] v;
        key_k_i = 3'd4;
        put(3168, 8'hEE, 1'b1);
        put(3500, 8'hEE, 1'b1);
        put(4095, 8'hEE, 1'b1);
        check("R6", pk_hash_o, exp_hash, "hash after out-of-range writes");
        check("R6", rej_seed_o, exp_seed, "seed after out-of-range writes");
        rd(1'b0, 1567, v);
        check("R6", 256'(v), 256'(pat(1536 + 1567, 5)), "encap last byte");
        rd(1'b0, 0, v);
        check("R6", 256'(v), 256'(pat(1536, 5)), "encap byte 0");
    endtask

    task automatic t_idle_we;
        key_k_i = 3'd4;
        put(3104 + 2, 8'hA5, 1'b0);
        put(3136 + 4, 8'hA5, 1'b0);
        check("R7", pk_hash_o, exp_hash, "hash with enable low");
        check("R7", rej_seed_o, exp_seed, "seed with enable low");
    endtask

    task automatic t_bad_k;
        logic [7:0] v;
        key_k_i = 3'd7;
        put(0, 8'h11, 1'b1);
        put(3110, 8'h22, 1'b1);
        key_k_i = 3'd1;
        put(3140, 8'h33, 1'b1);
        key_k_i = 3'd0;
        put(5, 8'h44, 1'b1);
        key_k_i = 3'd4;
        check("R10", pk_hash_o, exp_hash, "hash with unsupported K");
        check("R10", rej_seed_o, exp_seed, "seed with unsupported K");
        rd(1'b1, 0, v);
        check("R10", 256'(v), 256'(pat(0, 5)), "secret byte 0 with unsupported K");
        rd(1'b1, 5, v);
        check("R10", 256'(v), 256'(pat(5, 5)), "secret byte 5 with unsupported K");
    endtask

    task automatic t_boundary;
        logic [7:0] v;
        key_k_i = 3'd3;
        put(768, 8'h3C, 1'b1);
        key_k_i = 3'd2;
        put(768, 8'hB2, 1'b1);
        rd(1'b1, 768, v);
        check("R8", 256'(v), 256'(8'h3C), "K=3 addr 768 in secret memory");
        rd(1'b0, 0, v);
        check("R8", 256'(v), 256'(8'hB2), "K=2 addr 768 at encap local 0");
        // K=2 hash region begins at 1568
        put(1568, 8'h77, 1'b1);
        exp_hash[7:0] = 8'h77;
        check("R8", pk_hash_o, exp_hash, "K=2 hash base 1568");
    endtask

    task automatic t_latency;
        logic [7:0] v;
        rd(1'b1, 768, v);
        check("R9", 256'(v), 256'(8'h3C), "first read");
        @(negedge clk);
        rd_sel_i  = 1'b0;
        rd_addr_i = 11'd0;
        #1;
        check("R9", 256'(rd_byte_o), 256'(8'h3C), "held before edge");
        @(negedge clk);
        check("R9", 256'(rd_byte_o), 256'(8'hB2), "new data after one edge");
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        exp_hash = '0;
        exp_seed = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_full_load(2, 1);
        t_single_lane();
        t_full_load(4, 5);
        t_past_end();
        t_idle_we();
        t_bad_k();
        t_boundary();
        t_latency();
        finish_run();
    end

endmodule